// File: doc/BRIEF.md
# Halt-Gated Debug Command Decoder

This block sits behind a serial debug pipe and turns each 5-bit command code into persistent control state for the processor core. It holds the following state:

- eight sticky feature-disable flags;
- a flag that floats the core's bus pins;
- a two-bit mode that chooses, separately for trace and for breakpoint exceptions, whether the exception also enters emulator mode.

The serial shifter hands over one code per strobe. The core reports whether it is halted and raises trace and breakpoint exception requests. The block returns:

- the disable flags;
- an output-float control;
- a one-cycle emulator-entry pulse;
- a vector-offset select that marks a breakpoint that takes the alternate vector (offset 0x30);
- a one-cycle emulator-interrupt request.

Every command except the emulator-interrupt request changes state only while the core is halted. If such a command arrives while the core is running, it is dropped and an illegal-command pulse is raised instead. Code assignments and the exception-path registering are parameters.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After reset these outputs are 0: `dis_flags`, `outputs_off`, `emu_entry`, `exc_vec_alt`, `emu_irq` and `cmd_illegal`. The mode is both-normal, so trace and breakpoint requests raise no emulator entry.
- R2: A strobed code 0x10+i (i = 0..7) while halted sets `dis_flags[i]` on the next cycle. The other flags keep their values. Flags stay set until cleared. Bit order is: instruction cache, data cache, instruction translation cache, data translation cache, store buffer, branch cache, FPU, second issue pipe.
- R3: A strobed code 0x0F while halted clears all eight disable flags on the next cycle.
- R4: A strobed code 0x0D while halted sets `outputs_off`. Code 0x0E while halted clears it.
- R5: Codes 0x18..0x1B while halted load the mode with (code - 0x18). Bit 0 of the mode enables emulator entry on breakpoint and bit 1 enables it on trace.
- R6: A breakpoint request while mode bit 0 is set gives `emu_entry`=1 and `exc_vec_alt`=1 one cycle later. With mode bit 0 clear, a breakpoint request raises neither output.
- R7: A trace request while mode bit 1 is set gives `emu_entry`=1 one cycle later. A trace request never raises `exc_vec_alt`. The mode in force before a same-cycle mode command is the one used.
- R8: Codes 0x0D..0x1B strobed while `core_halted`=0 change no state. `cmd_illegal` is 1 for exactly the next cycle.
- R9: Codes 0x1C..0x1F give `emu_irq`=1 for the next cycle whether or not the core is halted. They never raise `cmd_illegal`.
- R10: Codes 0x00..0x0C change no state and raise no pulse, halted or not.
- R11: With `cmd_valid`=0 the code input is ignored and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 5 | Command code |
| core_halted | input | 1 | Core is halted |
| trace_req | input | 1 | Trace exception being taken |
| bkpt_req | input | 1 | Breakpoint exception being taken |
| dis_flags | output | 8 | Sticky feature-disable flags |
| outputs_off | output | 1 | Float core outputs and ignore core inputs |
| emu_entry | output | 1 | Pulse: exception also enters emulator mode |
| exc_vec_alt | output | 1 | Breakpoint uses alternate vector offset 0x30 |
| emu_irq | output | 1 | Pulse: emulator interrupt request |
| cmd_illegal | output | 1 | Pulse: halt-only command dropped while running |

## Verification
Every result is due exactly one clock after the stimulus that causes it. This covers flag, float and mode updates, and the illegal and interrupt pulses. With the default registered exception path, the entry and vector-select outputs also appear one clock after the request, using the mode held before that edge. The bench drives inputs on the falling edge and steps a behavioural model at the rising edge. It compares every output one time unit later, on every clock, so each result is checked in the cycle it is due and nowhere else.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL    = 2'd0,
      MODE_BKPT_EMU  = 2'd1,
      MODE_TRACE_EMU = 2'd2,
      MODE_BOTH_EMU  = 2'd3
   } exc_mode_e;

   localparam int MODE_BKPT_BIT  = 0;
   localparam int MODE_TRACE_BIT = 1;

   typedef struct packed {
      logic set_dis;
      logic clr_dis;
      logic float_on;
      logic float_off;
      logic set_mode;
      logic irq;
      logic illegal;
   } cmd_act_t;

endpackage

// File: rtl/dbg_cmd_classify.sv
module dbg_cmd_classify
   import dbg_cmd_pkg::*;
#(
   parameter int CMD_W     = 5,
   parameter int NUM_DIS   = 8,
   parameter int DIS_BASE  = 16,
   parameter int MODE_BASE = 24,
   parameter int IRQ_BASE  = 28,
   parameter int IRQ_SPAN  = 4,
   parameter int FLOAT_CODE = 13,
   parameter int REL_CODE  = 14,
   parameter int CLR_CODE  = 15
) (
   input  logic               cmd_valid,
   input  logic [CMD_W-1:0]   cmd_code,
   input  logic               core_halted,
   output cmd_act_t           act,
   output logic [NUM_DIS-1:0] dis_sel,
   output exc_mode_e          mode_sel
);

   localparam int CW1 = CMD_W + 1;
   localparam logic [CW1-1:0] DIS_LO  = CW1'(DIS_BASE);
   localparam logic [CW1-1:0] DIS_HI  = CW1'(DIS_BASE + NUM_DIS);
   localparam logic [CW1-1:0] MODE_LO = CW1'(MODE_BASE);
   localparam logic [CW1-1:0] MODE_HI = CW1'(MODE_BASE + 4);
   localparam logic [CW1-1:0] IRQ_LO  = CW1'(IRQ_BASE);
   localparam logic [CW1-1:0] IRQ_HI  = CW1'(IRQ_BASE + IRQ_SPAN);
   localparam logic [CMD_W-1:0] C_FLOAT = CMD_W'(FLOAT_CODE);
   localparam logic [CMD_W-1:0] C_REL   = CMD_W'(REL_CODE);
   localparam logic [CMD_W-1:0] C_CLR   = CMD_W'(CLR_CODE);
   localparam logic [CMD_W-1:0] C_MODE  = CMD_W'(MODE_BASE);

   logic [CW1-1:0]   code_x;
   logic [CMD_W-1:0] mode_off;
   logic in_dis, in_mode, in_irq, is_float, is_rel, is_clr;
   logic gated, accept;

   assign code_x   = {1'b0, cmd_code};
   assign mode_off = cmd_code - C_MODE;

   always_comb begin
      in_dis   = (code_x >= DIS_LO)  && (code_x < DIS_HI);
      in_mode  = (code_x >= MODE_LO) && (code_x < MODE_HI);
      in_irq   = (code_x >= IRQ_LO)  && (code_x < IRQ_HI);
      is_float = (cmd_code == C_FLOAT);
      is_rel   = (cmd_code == C_REL);
      is_clr   = (cmd_code == C_CLR);
      gated    = in_dis | in_mode | is_float | is_rel | is_clr;
      accept   = cmd_valid & core_halted;
   end

   always_comb begin
      act           = '0;
      act.set_dis   = accept & in_dis;
      act.clr_dis   = accept & is_clr;
      act.float_on  = accept & is_float;
      act.float_off = accept & is_rel;
      act.set_mode  = accept & in_mode;
      act.irq       = cmd_valid & in_irq;
      act.illegal   = cmd_valid & ~core_halted & gated;
   end

   for (genvar gi = 0; gi < NUM_DIS; gi++) begin : g_sel
      localparam logic [CMD_W-1:0] C_BIT = CMD_W'(DIS_BASE + gi);
      assign dis_sel[gi] = (cmd_code == C_BIT);
   end

   assign mode_sel = exc_mode_e'(mode_off[1:0]);

endmodule

// File: rtl/dbg_flag_bank.sv
module dbg_flag_bank #(
   parameter int NUM_DIS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic               clr_en,
   input  logic [NUM_DIS-1:0] sel,
   input  logic               float_on,
   input  logic               float_off,
   output logic [NUM_DIS-1:0] dis_flags,
   output logic               outputs_off
);

   for (genvar gi = 0; gi < NUM_DIS; gi++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (clr_en) begin
            flag_q <= 1'b0;
         end else if (set_en && sel[gi]) begin
            flag_q <= 1'b1;
         end
      end
      assign dis_flags[gi] = flag_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outputs_off <= 1'b0;
      end else if (float_on) begin
         outputs_off <= 1'b1;
      end else if (float_off) begin
         outputs_off <= 1'b0;
      end
   end

endmodule

// File: rtl/dbg_exc_router.sv
module dbg_exc_router
   import dbg_cmd_pkg::*;
#(
   parameter bit EXC_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mode_load,
   input  exc_mode_e mode_nxt,
   input  logic      trace_req,
   input  logic      bkpt_req,
   input  logic      irq_cmd,
   input  logic      illegal_cmd,
   output logic      emu_entry,
   output logic      exc_vec_alt,
   output logic      emu_irq,
   output logic      cmd_illegal
);

   exc_mode_e  mode_q;
   logic [1:0] mode_bits;
   logic       entry_d, vec_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_NORMAL;
      end else if (mode_load) begin
         mode_q <= mode_nxt;
      end
   end

   assign mode_bits = mode_q;

   always_comb begin
      entry_d = (trace_req & mode_bits[MODE_TRACE_BIT]) |
                (bkpt_req  & mode_bits[MODE_BKPT_BIT]);
      vec_d   = bkpt_req & mode_bits[MODE_BKPT_BIT];
   end

   if (EXC_REG) begin : g_exc_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            emu_entry   <= 1'b0;
            exc_vec_alt <= 1'b0;
         end else begin
            emu_entry   <= entry_d;
            exc_vec_alt <= vec_d;
         end
      end
   end else begin : g_exc_comb
      assign emu_entry   = entry_d;
      assign exc_vec_alt = vec_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         emu_irq     <= 1'b0;
         cmd_illegal <= 1'b0;
      end else begin
         emu_irq     <= irq_cmd;
         cmd_illegal <= illegal_cmd;
      end
   end

endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
   import dbg_cmd_pkg::*;
#(
   parameter int CMD_W      = 5,
   parameter int NUM_DIS    = 8,
   parameter int DIS_BASE   = 16,
   parameter int MODE_BASE  = 24,
   parameter int IRQ_BASE   = 28,
   parameter int IRQ_SPAN   = 4,
   parameter int FLOAT_CODE = 13,
   parameter int REL_CODE   = 14,
   parameter int CLR_CODE   = 15,
   parameter bit EXC_REG    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [CMD_W-1:0]   cmd_code,
   input  logic               core_halted,
   input  logic               trace_req,
   input  logic               bkpt_req,
   output logic [NUM_DIS-1:0] dis_flags,
   output logic               outputs_off,
   output logic               emu_entry,
   output logic               exc_vec_alt,
   output logic               emu_irq,
   output logic               cmd_illegal
);

   localparam int CODE_SPACE = 1 << CMD_W;

   if (NUM_DIS < 1) begin : g_bad_num
      $error("NUM_DIS must be at least 1");
   end
   if (DIS_BASE + NUM_DIS > CODE_SPACE || MODE_BASE + 4 > CODE_SPACE ||
       IRQ_BASE + IRQ_SPAN > CODE_SPACE) begin : g_bad_fit
      $error("command ranges exceed the code space");
   end
   if (!(DIS_BASE + NUM_DIS <= MODE_BASE || MODE_BASE + 4 <= DIS_BASE)) begin : g_bad_ovl
      $error("disable and mode ranges overlap");
   end
   if (IRQ_BASE < MODE_BASE + 4 && IRQ_BASE + IRQ_SPAN > MODE_BASE) begin : g_bad_irq
      $error("interrupt and mode ranges overlap");
   end

   cmd_act_t           act;
   logic [NUM_DIS-1:0] dis_sel;
   exc_mode_e          mode_sel;

   dbg_cmd_classify #(
      .CMD_W(CMD_W), .NUM_DIS(NUM_DIS), .DIS_BASE(DIS_BASE),
      .MODE_BASE(MODE_BASE), .IRQ_BASE(IRQ_BASE), .IRQ_SPAN(IRQ_SPAN),
      .FLOAT_CODE(FLOAT_CODE), .REL_CODE(REL_CODE), .CLR_CODE(CLR_CODE)
   ) u_classify (
      .cmd_valid   (cmd_valid),
      .cmd_code    (cmd_code),
      .core_halted (core_halted),
      .act         (act),
      .dis_sel     (dis_sel),
      .mode_sel    (mode_sel)
   );

   dbg_flag_bank #(.NUM_DIS(NUM_DIS)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_en      (act.set_dis),
      .clr_en      (act.clr_dis),
      .sel         (dis_sel),
      .float_on    (act.float_on),
      .float_off   (act.float_off),
      .dis_flags   (dis_flags),
      .outputs_off (outputs_off)
   );

   dbg_exc_router #(.EXC_REG(EXC_REG)) u_router (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_load   (act.set_mode),
      .mode_nxt    (mode_sel),
      .trace_req   (trace_req),
      .bkpt_req    (bkpt_req),
      .irq_cmd     (act.irq),
      .illegal_cmd (act.illegal),
      .emu_entry   (emu_entry),
      .exc_vec_alt (exc_vec_alt),
      .emu_irq     (emu_irq),
      .cmd_illegal (cmd_illegal)
   );

endmodule

// File: rtl/dbg_cmd_checker.sv
module dbg_cmd_checker #(
   parameter int CMD_W      = 5,
   parameter int NUM_DIS    = 8,
   parameter int DIS_BASE   = 16,
   parameter int MODE_BASE  = 24,
   parameter int IRQ_BASE   = 28,
   parameter int IRQ_SPAN   = 4,
   parameter int FLOAT_CODE = 13,
   parameter int REL_CODE   = 14,
   parameter int CLR_CODE   = 15,
   parameter bit EXC_REG    = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic [CMD_W-1:0]   cmd_code,
   input logic               core_halted,
   input logic               trace_req,
   input logic               bkpt_req,
   input logic [NUM_DIS-1:0] dis_flags,
   input logic               outputs_off,
   input logic               emu_entry,
   input logic               exc_vec_alt,
   input logic               emu_irq,
   input logic               cmd_illegal
);

   localparam int CW1 = CMD_W + 1;
   localparam logic [CW1-1:0] LO_G  = CW1'(FLOAT_CODE);
   localparam logic [CW1-1:0] HI_G  = CW1'(MODE_BASE + 4);
   localparam logic [CW1-1:0] LO_I  = CW1'(IRQ_BASE);
   localparam logic [CW1-1:0] HI_I  = CW1'(IRQ_BASE + IRQ_SPAN);
   localparam logic [CW1-1:0] LO_D  = CW1'(DIS_BASE);
   localparam logic [CW1-1:0] HI_D  = CW1'(DIS_BASE + NUM_DIS);
   localparam logic [CMD_W-1:0] C_CLR = CMD_W'(CLR_CODE);
   localparam logic [CMD_W-1:0] C_DB  = CMD_W'(DIS_BASE);

   logic [CW1-1:0]     cx;
   logic               is_gated, is_irq, is_dis;
   logic [NUM_DIS-1:0] tgt;

   assign cx       = {1'b0, cmd_code};
   assign is_gated = (cx >= LO_G) && (cx < HI_G);
   assign is_irq   = (cx >= LO_I) && (cx < HI_I);
   assign is_dis   = (cx >= LO_D) && (cx < HI_D);
   assign tgt      = NUM_DIS'(1) << (cmd_code - C_DB);

   assert_set_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && core_halted && is_dis) |=> ((dis_flags & $past(tgt)) == $past(tgt)));

   assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && core_halted && cmd_code == C_CLR) |=> (dis_flags == '0));

   assert_drop_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !core_halted && is_gated) |=>
         (cmd_illegal && $stable(dis_flags) && $stable(outputs_off)));

   assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && is_irq) |=> (emu_irq && !cmd_illegal));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(dis_flags) && $stable(outputs_off) && !cmd_illegal && !emu_irq));

   assert_vec_implies_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_vec_alt |-> emu_entry);

   if (EXC_REG) begin : g_reg_chk
      assert_entry_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!trace_req && !bkpt_req) |=> (!emu_entry && !exc_vec_alt));
   end else begin : g_comb_chk
      assert_entry_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!trace_req && !bkpt_req) |-> (!emu_entry && !exc_vec_alt));
   end

endmodule

bind dbg_cmd_decoder dbg_cmd_checker #(
   .CMD_W(CMD_W), .NUM_DIS(NUM_DIS), .DIS_BASE(DIS_BASE), .MODE_BASE(MODE_BASE),
   .IRQ_BASE(IRQ_BASE), .IRQ_SPAN(IRQ_SPAN), .FLOAT_CODE(FLOAT_CODE),
   .REL_CODE(REL_CODE), .CLR_CODE(CLR_CODE), .EXC_REG(EXC_REG)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
   .core_halted(core_halted), .trace_req(trace_req), .bkpt_req(bkpt_req),
   .dis_flags(dis_flags), .outputs_off(outputs_off), .emu_entry(emu_entry),
   .exc_vec_alt(exc_vec_alt), .emu_irq(emu_irq), .cmd_illegal(cmd_illegal)
);

// File: tb/test_dbg_cmd_decoder.sv
module test_dbg_cmd_decoder;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n;
   logic       cmd_valid;
   logic [4:0] cmd_code;
   logic       core_halted, trace_req, bkpt_req;
   logic [7:0] dis_flags;
   logic       outputs_off, emu_entry, exc_vec_alt, emu_irq, cmd_illegal;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [7:0] m_flags;
   bit         m_off, m_entry, m_vec, m_irq, m_ill;
   int         m_mode;

   dbg_cmd_decoder i_dbg_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .core_halted(core_halted), .trace_req(trace_req), .bkpt_req(bkpt_req),
      .dis_flags(dis_flags), .outputs_off(outputs_off), .emu_entry(emu_entry),
      .exc_vec_alt(exc_vec_alt), .emu_irq(emu_irq), .cmd_illegal(cmd_illegal)
   );

   task automatic chk(input string label, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s %s actual=%0h expected=%0h", req, label, what, act, exp);
      end
   endtask

   task automatic compare_all(input string label);
      chk(label, "R2", "dis_flags",   32'(dis_flags),   32'(m_flags));
      chk(label, "R4", "outputs_off", 32'(outputs_off), 32'(m_off));
      chk(label, "R6", "emu_entry",   32'(emu_entry),   32'(m_entry));
      chk(label, "R6", "exc_vec_alt", 32'(exc_vec_alt), 32'(m_vec));
      chk(label, "R9", "emu_irq",     32'(emu_irq),     32'(m_irq));
      chk(label, "R8", "cmd_illegal", 32'(cmd_illegal), 32'(m_ill));
   endtask

   // Behavioural reference: exception results use the mode held before the edge.
   task automatic model(input bit v, input int code, input bit h, input bit tr, input bit bk);
      bit gated;
      m_entry = (tr && (m_mode & 2) != 0) || (bk && (m_mode & 1) != 0);
      m_vec   = bk && (m_mode & 1) != 0;
      m_irq   = v && code >= 28;
      m_ill   = 0;
      gated   = (code >= 13 && code <= 27);
      if (v && gated) begin
         if (!h) m_ill = 1;
         else if (code == 13) m_off = 1;
         else if (code == 14) m_off = 0;
         else if (code == 15) m_flags = 8'h00;
         else if (code <= 23) m_flags[code-16] = 1'b1;
         else m_mode = code - 24;
      end
   endtask

   task automatic step(input bit v, input int code, input bit h, input bit tr,
                       input bit bk, input string label);
      @(negedge clk);
      cmd_valid   = v;
      cmd_code    = code[4:0];
      core_halted = h;
      trace_req   = tr;
      bkpt_req    = bk;
      @(posedge clk);
      model(v, code, h, tr, bk);
      #1;
      compare_all(label);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cmd_valid = 0; cmd_code = '0; core_halted = 0;
      trace_req = 0; bkpt_req = 0;
      m_flags = '0; m_off = 0; m_entry = 0; m_vec = 0; m_irq = 0; m_ill = 0; m_mode = 0;
      repeat (3) @(posedge clk);
      #1;
      compare_all("R1 in reset");
      @(negedge clk);
      rst_n = 1;

      // R1: reset mode is both-normal, requests raise nothing
      step(0, 0, 0, 1, 1, "R1 reset mode");
      step(0, 0, 0, 0, 0, "R1 idle");

      // R2: set each flag one by one while halted, cumulatively
      for (int i = 0; i < 8; i++) step(1, 16 + i, 1, 0, 0, "R2 set");
      step(1, 19, 1, 0, 0, "R2 set again");

      // R8: clear while running is dropped
      step(1, 15, 0, 0, 0, "R8 clear running");
      // R3: clear while halted
      step(1, 15, 1, 0, 0, "R3 clear");
      step(1, 18, 1, 0, 0, "R2 single");
      // R8: disable while running dropped
      step(1, 21, 0, 0, 0, "R8 disable running");

      // R4: float then release; release while running dropped
      step(1, 13, 1, 0, 0, "R4 float");
      step(1, 14, 0, 0, 0, "R8 release running");
      step(1, 14, 1, 0, 0, "R4 release");
      step(1, 13, 0, 0, 0, "R8 float running");

      // R5, R6, R7: each mode against trace, breakpoint and both
      for (int m = 0; m < 4; m++) begin
         step(1, 24 + m, 1, 0, 0, "R5 mode");
         step(0, 0, 1, 1, 0, "R7 trace");
         step(0, 0, 1, 0, 1, "R6 bkpt");
         step(0, 0, 1, 1, 1, "R7 both");
      end
      // R7: same-cycle mode change uses the previous mode
      step(1, 24, 1, 1, 1, "R7 old mode");
      step(0, 0, 1, 1, 1, "R7 new mode");
      step(1, 27, 0, 0, 0, "R8 mode running");
      step(0, 0, 1, 0, 1, "R8 mode kept");

      // R9: interrupt codes, halted or not
      for (int c = 28; c < 32; c++) begin
         step(1, c, c[0], 0, 0, "R9 irq");
      end

      // R10: unused low codes
      step(1, 17, 1, 0, 0, "R2 before R10");
      for (int c = 0; c < 13; c++) begin
         step(1, c, c[0], 0, 0, "R10 unused");
      end

      // R11: no strobe, code present
      step(0, 15, 1, 0, 0, "R11 no strobe");
      step(0, 22, 1, 0, 0, "R11 no strobe");

      // mixed stimulus across all requirements
      for (int k = 0; k < 600; k++) begin
         step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
              bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
              bit'($urandom_range(0, 1)), "mixed");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule